// File: doc/BRIEF.md
# SD Card Host Register Front End

This block is the software-facing side of a simple SD card host. A processor reaches six 32-bit registers over a plain word-wide register bus and moves the card's command line and four-bit data bus in steps of one byte or one word. A write to the command port sends a byte out on the command line. A write to the data port sends a 32-bit word out as eight four-bit beats. A trigger in the start register captures a 32-bit word from the data bus. The command line receiver hunts for a start bit and then gathers consecutive bytes. A programmable divider derives the card clock from the system clock.

Each transfer kind has its own enable bit and its own pending flag. Software polls the pending flags or watches a level interrupt output that is high while any flag is set. When no card is present, the ports read back all ones and writes to them start nothing. CRC generation, card protocol state and DMA are left to software and to other blocks.

Top module: `sd_host_regs`

## Requirements
- R1: After reset every register (index 0 divider, 1 enable, 2 pending, 3 start, 4 command port, 5 data port; byte address = index x 4) reads zero. sd_cmd_oe, sd_dat_oe and irq are low. Read data appears on bus_rdata with bus_rvalid high in the cycle after the read request.
- R2: sd_clk is a 50% duty clock with a period of 2 x max(D,1) system clocks, where D is the divider register value.
- R3: A write to the command port sends bits 7:0 of the written word on sd_cmd_o, most significant bit first. Each bit is held across exactly one rising edge of sd_clk, changes only after a falling edge, and is driven with sd_cmd_oe high.
- R4: When the command byte finishes, pending bit 0 is set if enable bit 0 is 1. Starting a new command transmit clears pending bit 0. With enable bit 0 at 0, a finished command transmit leaves pending bit 0 at 0.
- R5: A write to the data port sends the word on sd_dat_o as eight nibbles with sd_dat_oe high. Bits 31:28 go first and bits 3:0 go last, one nibble per sd_clk period, changing only after falling edges.
- R6: When the data word finishes, pending bit 2 is set if enable bit 2 is 1.
- R7: Writing 1 to start bit 1 captures sd_dat_i on the next eight rising sd_clk edges. The first nibble lands in bits 31:28. The data port then reads the captured word, and pending bit 3 is set if enable bit 3 is 1.
- R8: Writing 1 to start bit 0 sends again the last byte that was sent through the command port. The start register reads back the value last written to its bits 1:0.
- R9: While enable bit 1 is 1, the command receiver ignores high bits until it samples a low bit on a rising sd_clk edge. That low bit becomes bit 7 of a byte. The receiver then gathers back-to-back 8-bit groups. Each group goes to bits 7:0 of the command port and sets pending bit 1.
- R10: Writing the pending register clears receive bits 1 and 3 wherever the written value has a 1. The written values of transmit bits 0 and 2 have no effect.
- R11: With card_present low, the command port reads 0x000000FF and the data port reads 0xFFFFFFFF. Port writes and start triggers launch no transfer, and no pending flag is set.
- R12: Accesses with bus_be other than 4'hF, or to index 6 or above, leave every register unchanged and read zero.
- R13: irq is high exactly when at least one pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; register index is bits ADDR_W-1:2 |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 32 | Read data |
| card_present | input | 1 | High while a card is inserted |
| sd_clk | output | 1 | Divided card clock |
| sd_cmd_o | output | 1 | Command line output value |
| sd_cmd_oe | output | 1 | Command line output enable |
| sd_cmd_i | input | 1 | Command line input value |
| sd_dat_o | output | 4 | Data bus output value |
| sd_dat_oe | output | 1 | Data bus output enable |
| sd_dat_i | input | 4 | Data bus input value |
| irq | output | 1 | Level interrupt, any pending bit set |

## Verification
The embedded assertions check several rules on every cycle. Driven command and data bits change only after a falling card-clock tick. A transmit pending flag rises only two cycles after its line was released. A receive pending flag falls only after a clearing write. No line is driven in the cycle after a cycle without a card. The bench scenarios show the rest: the bit order of each transfer against chosen patterns, the measured clock period for two divider values, the start-bit hunt and byte continuation of the command receiver, the read values with no card, and unmapped or partial accesses.

// File: rtl/sdh_pkg.sv
package sdh_pkg;
   localparam int WORD_W    = 32;
   localparam int NUM_REGS  = 6;
   localparam int CMD_BITS  = 8;
   localparam int DAT_LANES = 4;
   localparam int DAT_BEATS = WORD_W / DAT_LANES;

   // register indices (byte address >> 2)
   localparam logic [2:0] RIX_DIV   = 3'd0;
   localparam logic [2:0] RIX_ENA   = 3'd1;
   localparam logic [2:0] RIX_PEND  = 3'd2;
   localparam logic [2:0] RIX_START = 3'd3;
   localparam logic [2:0] RIX_CMD   = 3'd4;
   localparam logic [2:0] RIX_DAT   = 3'd5;

   // flag bit positions shared by enable and pending
   localparam int FLG_CMD_TX = 0;
   localparam int FLG_CMD_RX = 1;
   localparam int FLG_DAT_TX = 2;
   localparam int FLG_DAT_RX = 3;

   // start register trigger bits
   localparam int GO_CMD_TX = 0;
   localparam int GO_DAT_RX = 1;

   typedef struct packed {
      logic dat_rx;
      logic dat_tx;
      logic cmd_rx;
      logic cmd_tx;
   } sdh_flags_t;
endpackage

// File: rtl/sdh_clkgen.sv
module sdh_clkgen #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             sd_clk,
   output logic             rise,
   output logic             fall
);
   logic [DIV_W-1:0] half_m1;
   logic [DIV_W-1:0] cnt_q;
   logic             wrap;

   // a divider of zero behaves as one
   assign half_m1 = (div == '0) ? '0 : div - 1'b1;
   assign wrap    = (cnt_q >= half_m1);
   assign rise    = wrap & ~sd_clk;
   assign fall    = wrap &  sd_clk;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         sd_clk <= 1'b0;
      end else if (wrap) begin
         cnt_q  <= '0;
         sd_clk <= ~sd_clk;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/sdh_txshift.sv
module sdh_txshift #(
   parameter int LANE_W = 1,
   parameter int BEATS  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rise,
   input  logic                    fall,
   input  logic                    load,
   input  logic [LANE_W*BEATS-1:0] load_word,
   output logic                    busy,
   output logic                    done,
   output logic [LANE_W-1:0]       lane_o
);
   localparam int WORD_W = LANE_W * BEATS;
   localparam int CNT_W  = $clog2(BEATS);

   if (BEATS < 2) begin : g_bad_beats
      $error("sdh_txshift: BEATS must be at least 2");
   end
   if (LANE_W < 1) begin : g_bad_lane
      $error("sdh_txshift: LANE_W must be at least 1");
   end

   logic [WORD_W-1:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         cnt_q  <= '0;
         seen_q <= 1'b0;
         busy   <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (load) begin
               sh_q   <= load_word;
               cnt_q  <= '0;
               seen_q <= 1'b0;
               busy   <= 1'b1;
            end
         end else if (rise) begin
            seen_q <= 1'b1;
         end else if (fall && seen_q) begin
            seen_q <= 1'b0;
            if (cnt_q == CNT_W'(BEATS - 1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               sh_q  <= sh_q << LANE_W;
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign lane_o = busy ? sh_q[WORD_W-1 -: LANE_W] : '1;
endmodule

// File: rtl/sdh_rxcap.sv
module sdh_rxcap #(
   parameter int LANE_W = 4,
   parameter int BEATS  = 8,
   parameter bit HUNT   = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rise,
   input  logic                    arm,
   input  logic [LANE_W-1:0]       lane_i,
   output logic                    busy,
   output logic                    done,
   output logic [LANE_W*BEATS-1:0] word
);
   localparam int WORD_W = LANE_W * BEATS;
   localparam int CNT_W  = $clog2(BEATS);

   if (BEATS < 2) begin : g_bad_beats
      $error("sdh_rxcap: BEATS must be at least 2");
   end

   logic [WORD_W-1:0] sh_q;
   logic [WORD_W-1:0] sh_nxt;
   logic [CNT_W-1:0]  cnt_q;
   logic              last;

   assign sh_nxt = {sh_q[WORD_W-LANE_W-1:0], lane_i};
   assign last   = (cnt_q == CNT_W'(BEATS - 1));

   if (HUNT) begin : g_hunt
      // arm is a level: hunt for a low start beat, then run continuously
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sh_q <= '0; cnt_q <= '0; busy <= 1'b0; done <= 1'b0; word <= '0;
         end else begin
            done <= 1'b0;
            if (!arm) begin
               busy  <= 1'b0;
               cnt_q <= '0;
            end else if (rise) begin
               if (!busy) begin
                  if (lane_i == '0) begin
                     busy  <= 1'b1;
                     sh_q  <= sh_nxt;
                     cnt_q <= CNT_W'(1);
                  end
               end else begin
                  sh_q <= sh_nxt;
                  if (last) begin
                     word  <= sh_nxt;
                     done  <= 1'b1;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
         end
      end
   end else begin : g_oneshot
      // arm is a pulse: capture exactly one word
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sh_q <= '0; cnt_q <= '0; busy <= 1'b0; done <= 1'b0; word <= '0;
         end else begin
            done <= 1'b0;
            if (!busy) begin
               if (arm) begin
                  busy  <= 1'b1;
                  cnt_q <= '0;
               end
            end else if (rise) begin
               sh_q <= sh_nxt;
               if (last) begin
                  word <= sh_nxt;
                  done <= 1'b1;
                  busy <= 1'b0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/sd_host_regs.sv
module sd_host_regs
   import sdh_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DIV_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [3:0]        bus_be,
   input  logic [31:0]       bus_wdata,
   output logic              bus_rvalid,
   output logic [31:0]       bus_rdata,
   input  logic              card_present,
   output logic              sd_clk,
   output logic              sd_cmd_o,
   output logic              sd_cmd_oe,
   input  logic              sd_cmd_i,
   output logic [3:0]        sd_dat_o,
   output logic              sd_dat_oe,
   input  logic [3:0]        sd_dat_i,
   output logic              irq
);
   localparam int IDX_W = ADDR_W - 2;

   if (ADDR_W < 5) begin : g_bad_addr
      $error("sd_host_regs: ADDR_W must be at least 5");
   end
   if (DIV_W < 1 || DIV_W > WORD_W) begin : g_bad_div
      $error("sd_host_regs: DIV_W must lie in 1..32");
   end

   // ---------------- bus decode ----------------
   logic [IDX_W-1:0] idx;
   logic [2:0]       rsel;
   logic             mapped, full_word, wr_hit, rd_req;
   logic             wr_div, wr_ena, wr_pend, wr_start, wr_cmd, wr_dat;

   assign idx       = bus_addr[ADDR_W-1:2];
   assign rsel      = idx[2:0];
   assign mapped    = (idx < IDX_W'(NUM_REGS));
   assign full_word = (bus_be == 4'hF);
   assign wr_hit    = bus_sel & bus_we & full_word & mapped;
   assign rd_req    = bus_sel & ~bus_we;
   assign wr_div    = wr_hit && (rsel == RIX_DIV);
   assign wr_ena    = wr_hit && (rsel == RIX_ENA);
   assign wr_pend   = wr_hit && (rsel == RIX_PEND);
   assign wr_start  = wr_hit && (rsel == RIX_START);
   assign wr_cmd    = wr_hit && (rsel == RIX_CMD);
   assign wr_dat    = wr_hit && (rsel == RIX_DAT);

   // ---------------- registers ----------------
   logic [DIV_W-1:0] div_q;
   sdh_flags_t       en_q, pend_q, pend_n;
   logic [1:0]       start_q;
   logic [7:0]       cmd_hold_q;

   // ---------------- engines ----------------
   logic              clk_rise, clk_fall;
   logic              cmd_busy, cmd_done, dat_busy, dat_done;
   logic              crx_busy, crx_done, drx_busy, drx_done;
   logic              cmd_launch, dat_launch, drx_arm;
   logic [7:0]        cmd_load;
   logic [7:0]        crx_byte;
   logic [WORD_W-1:0] drx_word;

   assign cmd_launch = card_present & ~cmd_busy &
                       (wr_cmd | (wr_start & bus_wdata[GO_CMD_TX]));
   assign cmd_load   = wr_cmd ? bus_wdata[7:0] : cmd_hold_q;
   assign dat_launch = card_present & ~dat_busy & wr_dat;
   assign drx_arm    = card_present & wr_start & bus_wdata[GO_DAT_RX];

   sdh_clkgen #(.DIV_W(DIV_W)) u_clkgen (
      .clk(clk), .rst_n(rst_n), .div(div_q),
      .sd_clk(sd_clk), .rise(clk_rise), .fall(clk_fall)
   );

   sdh_txshift #(.LANE_W(1), .BEATS(CMD_BITS)) u_cmd_tx (
      .clk(clk), .rst_n(rst_n), .rise(clk_rise), .fall(clk_fall),
      .load(cmd_launch), .load_word(cmd_load),
      .busy(cmd_busy), .done(cmd_done), .lane_o(sd_cmd_o)
   );

   sdh_txshift #(.LANE_W(DAT_LANES), .BEATS(DAT_BEATS)) u_dat_tx (
      .clk(clk), .rst_n(rst_n), .rise(clk_rise), .fall(clk_fall),
      .load(dat_launch), .load_word(bus_wdata),
      .busy(dat_busy), .done(dat_done), .lane_o(sd_dat_o)
   );

   sdh_rxcap #(.LANE_W(1), .BEATS(CMD_BITS), .HUNT(1'b1)) u_cmd_rx (
      .clk(clk), .rst_n(rst_n), .rise(clk_rise), .arm(en_q.cmd_rx),
      .lane_i(sd_cmd_i), .busy(crx_busy), .done(crx_done), .word(crx_byte)
   );

   sdh_rxcap #(.LANE_W(DAT_LANES), .BEATS(DAT_BEATS), .HUNT(1'b0)) u_dat_rx (
      .clk(clk), .rst_n(rst_n), .rise(clk_rise), .arm(drx_arm),
      .lane_i(sd_dat_i), .busy(drx_busy), .done(drx_done), .word(drx_word)
   );

   assign sd_cmd_oe = cmd_busy;
   assign sd_dat_oe = dat_busy;

   // ---------------- pending flags ----------------
   always_comb begin
      pend_n = pend_q;
      if (cmd_done && en_q.cmd_tx) pend_n.cmd_tx = 1'b1;
      if (dat_done && en_q.dat_tx) pend_n.dat_tx = 1'b1;
      if (crx_done && en_q.cmd_rx) pend_n.cmd_rx = 1'b1;
      if (drx_done && en_q.dat_rx) pend_n.dat_rx = 1'b1;
      if (wr_pend) begin
         if (bus_wdata[FLG_CMD_RX]) pend_n.cmd_rx = 1'b0;
         if (bus_wdata[FLG_DAT_RX]) pend_n.dat_rx = 1'b0;
      end
      if (cmd_launch) pend_n.cmd_tx = 1'b0;
      if (dat_launch) pend_n.dat_tx = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q      <= '0;
         en_q       <= '0;
         pend_q     <= '0;
         start_q    <= '0;
         cmd_hold_q <= '0;
      end else begin
         pend_q <= pend_n;
         if (wr_div)   div_q   <= bus_wdata[DIV_W-1:0];
         if (wr_ena)   en_q    <= sdh_flags_t'(bus_wdata[3:0]);
         if (wr_start) start_q <= bus_wdata[1:0];
         if (cmd_launch && wr_cmd) cmd_hold_q <= bus_wdata[7:0];
      end
   end

   assign irq = |pend_q;

   // ---------------- read path ----------------
   logic [31:0] rd_val;

   always_comb begin
      rd_val = '0;
      case (rsel)
         RIX_DIV:   rd_val = 32'(div_q);
         RIX_ENA:   rd_val = {28'd0, en_q};
         RIX_PEND:  rd_val = {28'd0, pend_q};
         RIX_START: rd_val = {30'd0, start_q};
         RIX_CMD:   rd_val = card_present ? {24'd0, crx_byte} : 32'h0000_00FF;
         RIX_DAT:   rd_val = card_present ? drx_word : 32'hFFFF_FFFF;
         default:   rd_val = '0;
      endcase
      if (!full_word || !mapped) rd_val = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= rd_req;
         bus_rdata  <= rd_req ? rd_val : '0;
      end
   end

   logic unused_bits;
   assign unused_bits = ^{bus_addr[1:0], bus_wdata, crx_busy, drx_busy};

   // ---------------- assertions ----------------
   p_cmd_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd_oe && $past(sd_cmd_oe) && (sd_cmd_o != $past(sd_cmd_o))) |-> $past(clk_fall))
      else $error("R3: command bit changed outside a falling tick");

   p_dat_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_dat_oe && $past(sd_dat_oe) && (sd_dat_o != $past(sd_dat_o))) |-> $past(clk_fall))
      else $error("R5: data nibble changed outside a falling tick");

   p_txpend_after_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q.cmd_tx) |-> (!sd_cmd_oe && $past(sd_cmd_oe, 2)))
      else $error("R4: command pending rose without a finished transmit");

   p_rxpend_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_q.cmd_rx) |-> $past(wr_pend && bus_wdata[FLG_CMD_RX]))
      else $error("R10: command receive pending fell without a clearing write");

   p_absent_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !card_present |=> (!$rose(sd_cmd_oe) && !$rose(sd_dat_oe)))
      else $error("R11: a line was driven after a cycle without a card");
endmodule

// File: tb/sd_host_regs_test.sv
`timescale 1ns/1ps
module sd_host_regs_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [3:0]  bus_be = 4'hF;
   logic [31:0] bus_wdata = '0;
   logic        bus_rvalid;
   logic [31:0] bus_rdata;
   logic        card_present = 1'b1;
   logic        sd_clk, sd_cmd_o, sd_cmd_oe, sd_dat_oe, irq;
   logic        sd_cmd_i = 1'b1;
   logic [3:0]  sd_dat_o;
   logic [3:0]  sd_dat_i = 4'h0;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   sd_host_regs uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
      .card_present(card_present), .sd_clk(sd_clk),
      .sd_cmd_o(sd_cmd_o), .sd_cmd_oe(sd_cmd_oe), .sd_cmd_i(sd_cmd_i),
      .sd_dat_o(sd_dat_o), .sd_dat_oe(sd_dat_oe), .sd_dat_i(sd_dat_i),
      .irq(irq)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(int idx, logic [31:0] d, logic [3:0] be = 4'hF);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 5'(idx * 4);
      bus_wdata = d; bus_be = be;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; bus_be = 4'hF;
   endtask

   task automatic rd(int idx, output logic [31:0] d, input logic [3:0] be = 4'hF);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 5'(idx * 4); bus_be = be;
      @(negedge clk);
      bus_sel = 1'b0; bus_be = 4'hF;
      d = bus_rdata;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic watch_cmd(string req, logic [7:0] exp);
      logic [7:0] got;
      int bad = 0;
      for (int k = 0; k < 8; k++) begin
         @(posedge sd_clk); #1;
         got[7-k] = sd_cmd_o;
         if (!sd_cmd_oe) bad++;
      end
      chk(req, {23'd0, bad != 0, got}, {24'd0, exp});
   endtask

   task automatic watch_dat(string req, logic [31:0] exp);
      logic [31:0] got;
      int bad = 0;
      for (int k = 0; k < 8; k++) begin
         @(posedge sd_clk); #1;
         got[31-4*k -: 4] = sd_dat_o;
         if (!sd_dat_oe) bad++;
      end
      chk(req, got, exp);
      chk({req, " oe"}, bad, 0);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      for (int i = 0; i < 6; i++) begin
         rd(i, v);
         chk("R1 reg reset", v, 0);
         chk("R1 rvalid", {31'd0, bus_rvalid}, 1);
      end
      chk("R1 lines idle", {29'd0, sd_cmd_oe, sd_dat_oe, irq}, 0);
   endtask

   task automatic t_clock();
      realtime t0, t1, t2;
      wr(0, 3);
      @(posedge sd_clk); @(posedge sd_clk);
      t0 = $realtime; @(negedge sd_clk); t1 = $realtime; @(posedge sd_clk); t2 = $realtime;
      chk("R2 div3 high", 32'(int'(t1 - t0)), 30);
      chk("R2 div3 period", 32'(int'(t2 - t0)), 60);
      wr(0, 0);
      @(posedge sd_clk); @(posedge sd_clk);
      t0 = $realtime; @(negedge sd_clk); t1 = $realtime; @(posedge sd_clk); t2 = $realtime;
      chk("R2 div0 high", 32'(int'(t1 - t0)), 10);
      chk("R2 div0 period", 32'(int'(t2 - t0)), 20);
   endtask

   task automatic t_cmd_tx();
      logic [31:0] v;
      wr(0, 2);
      wr(1, 32'h1);
      wr(4, 32'hFFFF_FFA5);
      watch_cmd("R3 byte A5", 8'hA5);
      idle(20);
      rd(2, v);
      chk("R4 pending set", v & 32'h1, 32'h1);
      chk("R13 irq high", {31'd0, irq}, 1);
      wr(4, 32'h3C);
      rd(2, v);
      chk("R4 launch clears", v & 32'h1, 0);
      idle(60);
      wr(1, 32'h0);
      wr(4, 32'h11);
      watch_cmd("R3 byte 11", 8'h11);
      idle(20);
      rd(2, v);
      chk("R4 disabled stays clear", v & 32'h1, 0);
   endtask

   task automatic t_restart();
      logic [31:0] v;
      wr(1, 32'h1);
      wr(3, 32'h1);
      watch_cmd("R8 resend", 8'h11);
      idle(20);
      rd(3, v);
      chk("R8 start readback", v, 32'h1);
   endtask

   task automatic t_dat_tx();
      logic [31:0] v;
      wr(1, 32'h4);
      wr(5, 32'h1234_ABCD);
      watch_dat("R5 word", 32'h1234_ABCD);
      idle(20);
      rd(2, v);
      chk("R6 pending", v & 32'h4, 32'h4);
   endtask

   task automatic t_dat_rx();
      logic [31:0] v;
      logic [31:0] w = 32'h9E3C_5A71;
      wr(1, 32'h8);
      sd_dat_i = w[31:28];
      wr(3, 32'h2);
      for (int k = 0; k < 8; k++) begin
         @(posedge sd_clk); #1;
         if (k < 7) sd_dat_i = w[27-4*k -: 4];
      end
      idle(4);
      rd(5, v);
      chk("R7 captured word", v, w);
      rd(2, v);
      chk("R7 pending", v & 32'h8, 32'h8);
   endtask

   task automatic t_cmd_rx();
      logic [31:0] v;
      logic [7:0] b1 = 8'h3A, b2 = 8'hC5;
      wr(0, 8);
      sd_cmd_i = 1'b1;
      wr(1, 32'h2);
      repeat (3) @(posedge sd_clk);
      #1;
      for (int k = 0; k < 8; k++) begin
         sd_cmd_i = b1[7-k];
         @(posedge sd_clk); #1;
      end
      rd(4, v);
      chk("R9 first byte", v, 32'h3A);
      rd(2, v);
      chk("R9 pending", v & 32'h2, 32'h2);
      for (int k = 0; k < 8; k++) begin
         sd_cmd_i = b2[7-k];
         @(posedge sd_clk); #1;
      end
      sd_cmd_i = 1'b1;
      idle(3);
      rd(4, v);
      chk("R9 next byte", v, 32'hC5);
      wr(1, 32'h0);
   endtask

   task automatic t_pend_w1c();
      logic [31:0] v;
      wr(0, 1);
      rd(2, v);
      chk("R10 all set", v, 32'hF);
      wr(2, 32'hF);
      rd(2, v);
      chk("R10 only rx cleared", v, 32'h5);
      chk("R13 irq still high", {31'd0, irq}, 1);
      wr(4, 32'h00);
      wr(5, 32'h0);
      idle(60);
      rd(2, v);
      chk("R13 pending empty", v, 0);
      chk("R13 irq low", {31'd0, irq}, 0);
   endtask

   task automatic t_absent();
      logic [31:0] v;
      int drove = 0;
      card_present = 1'b0;
      wr(1, 32'hF);
      wr(4, 32'h55);
      wr(5, 32'hDEAD_BEEF);
      wr(3, 32'h3);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (sd_cmd_oe || sd_dat_oe) drove++;
      end
      chk("R11 no drive", drove, 0);
      rd(4, v);
      chk("R11 cmd read", v, 32'hFF);
      rd(5, v);
      chk("R11 dat read", v, 32'hFFFF_FFFF);
      rd(2, v);
      chk("R11 no pending", v, 0);
      card_present = 1'b1;
      wr(1, 32'h0);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      wr(0, 5);
      rd(6, v);
      chk("R12 index 6", v, 0);
      rd(7, v);
      chk("R12 index 7", v, 0);
      wr(6, 32'hFFFF_FFFF);
      wr(1, 32'hF, 4'h3);
      rd(1, v);
      chk("R12 partial write dropped", v, 0);
      rd(0, v, 4'h1);
      chk("R12 partial read zero", v, 0);
      rd(0, v);
      chk("R12 divider unchanged", v, 5);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_clock();
      t_cmd_tx();
      t_restart();
      t_dat_tx();
      t_dat_rx();
      t_cmd_rx();
      t_pend_w1c();
      t_absent();
      t_unmapped();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule